// File: doc/BRIEF.md
# Staged Logical Left Shifter

This block moves a 32-bit operand toward its most significant end by any distance from 0 to 31 bit positions. The distance comes from an unsigned 5-bit amount. Positions left empty at the low end become zero, and bits pushed past bit 31 are discarded. It is the datapath core of a shift-left-logical instruction and has no clock and no reset: the result follows the inputs through combinational logic alone.

The shift is split by the digits of the amount. A first level of four-way selectors shifts by 0, 1, 2 or 3 under amount bits [1:0]. A second level of four-way selectors shifts by 0, 4, 8 or 12 under bits [3:2]. A final level of two-way selectors shifts by 0 or 16 under bit 4. Each level takes the previous result, so any path from an input to an output crosses three selectors.

Top module: `radix4_shl`

## Requirements
- R1: For every amount from 0 to 31, res_o equals op_i shifted left by amt_i with the upper overflow discarded, keeping 32 bits.
- R2: With amt_i equal to 0, res_o equals op_i bit for bit.
- R3: Every result bit at a position below amt_i is 0, even when op_i is all ones.
- R4: Result bit i equals operand bit i−amt_i for i ≥ amt_i, so the number of set bits in res_o never exceeds the number in op_i.
- R5: Amounts 1, 2 and 3, which use only bits [1:0], shift by exactly that many positions.
- R6: Amounts 4, 8 and 12, which use only bits [3:2], shift by exactly that many positions.
- R7: Amount 16, which uses only bit 4, moves the low half of the operand into the high half and zeroes the low half.
- R8: The output changes with the inputs alone, without any clock edge.
- R9: An operand with a single set bit at position p yields a single set bit at p+amt_i when p+amt_i ≤ 31, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 32 | Operand to be shifted |
| amt_i | input | 5 | Unsigned shift distance, 0 to 31 |
| res_o | output | 32 | Shifted operand, zero-filled from the low end |

## Verification
Four fixed operands are swept over all 32 amounts. All zeros catches any stray constant, all ones shows where the zero fill begins, a lone bit 0 shows where each amount lands, and a lone bit 31 shows when the overflow bit is dropped. Amounts that use one selector level at a time show which level is at fault. Random operands over random amounts catch cross-bit wiring mistakes that the sparse patterns miss. A change of the inputs between clock edges confirms that no register sits in the path.

// File: rtl/shl_pkg.sv
package shl_pkg;
    parameter int unsigned SHL_WIDTH = 32;
    localparam int unsigned SHL_AMT_W = $clog2(SHL_WIDTH);
    typedef logic [SHL_WIDTH-1:0] shl_word_t;
    typedef logic [SHL_AMT_W-1:0] shl_amt_t;
endpackage

// File: rtl/shl_stage.sv
// One selector level: picks among 2**SEL_W copies of the input, copy k
// being the input moved up by k*STEP with zeros filling from the bottom.
module shl_stage #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned SEL_W = 2,
    parameter int unsigned STEP  = 1
) (
    input  logic [WIDTH-1:0] in_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [WIDTH-1:0] out_o
);
    localparam int unsigned NCAND = 1 << SEL_W;
    localparam logic [WIDTH-1:0] ZERO_VEC = '0;

    logic [WIDTH-1:0] cand [NCAND];

    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            if (b >= k * STEP) begin : g_take
                assign cand[k][b] = in_i[b - k * STEP];
            end else begin : g_fill
                assign cand[k][b] = ZERO_VEC[b];
            end
        end
    end

    always_comb begin
        out_o = cand[sel_i];
    end
endmodule

// File: rtl/radix4_shl.sv
module radix4_shl
    import shl_pkg::*;
#(
    parameter int unsigned WIDTH = SHL_WIDTH,
    parameter int unsigned AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] op_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [WIDTH-1:0] res_o
);
    localparam int unsigned N_QUAD  = AMT_W / 2;
    localparam int unsigned HAS_BIN = AMT_W % 2;
    localparam int unsigned N_STG   = N_QUAD + HAS_BIN;

    logic [WIDTH-1:0] lvl_d [N_STG+1];

    assign lvl_d[0] = op_i;

    for (genvar s = 0; s < N_QUAD; s++) begin : g_quad
        shl_stage #(
            .WIDTH(WIDTH),
            .SEL_W(2),
            .STEP (1 << (2 * s))
        ) u_stage (
            .in_i (lvl_d[s]),
            .sel_i(amt_i[2*s +: 2]),
            .out_o(lvl_d[s+1])
        );
    end

    if (HAS_BIN != 0) begin : g_bin
        shl_stage #(
            .WIDTH(WIDTH),
            .SEL_W(1),
            .STEP (1 << (AMT_W - 1))
        ) u_stage (
            .in_i (lvl_d[N_QUAD]),
            .sel_i(amt_i[AMT_W-1 -: 1]),
            .out_o(lvl_d[N_STG])
        );
    end

    assign res_o = lvl_d[N_STG];
endmodule

// File: rtl/radix4_shl_chk.sv
module radix4_shl_chk #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned AMT_W = 5
) (
    input logic [WIDTH-1:0] op_i,
    input logic [AMT_W-1:0] amt_i,
    input logic [WIDTH-1:0] res_o
);
    logic [WIDTH-1:0] keep_mask;
    assign keep_mask = {WIDTH{1'b1}} << amt_i;

    always_comb begin
        if (!$isunknown({op_i, amt_i, res_o})) begin
            AST_SHIFT_MATCH: assert (res_o == (op_i << amt_i)); // R1
            AST_ZERO_PASS: assert (amt_i != '0 || res_o == op_i); // R2
            AST_LOW_FILL: assert ((res_o & ~keep_mask) == '0); // R3
            AST_POP_BOUND: assert ($countones(res_o) <= $countones(op_i)); // R4
            AST_ONEHOT_KEEP: assert (!$onehot0(op_i) || $onehot0(res_o)); // R9
        end
    end
endmodule

bind radix4_shl radix4_shl_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
    .op_i (op_i),
    .amt_i(amt_i),
    .res_o(res_o)
);

// File: tb/radix4_shl_tb.sv
module radix4_shl_tb;
    logic        clk = 1'b0;
    logic [31:0] op;
    logic [4:0]  amt;
    logic [31:0] res;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #4 clk = ~clk;

    radix4_shl u_dut (.op_i(op), .amt_i(amt), .res_o(res));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%h amt=%0d act=%h exp=%h", tag, op, amt, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [31:0] o, input logic [4:0] a);
        @(posedge clk);
        op  = o;
        amt = a;
        @(negedge clk);
        check(tag, res, o << a);
    endtask

    task automatic t_reset_state;
        op = '0; amt = '0;
        @(negedge clk);
        check("R2 idle", res, 32'h0);
    endtask

    task automatic t_zero_amount;
        apply("R2", 32'hDEADBEEF, 5'd0);
        apply("R2", 32'h80000001, 5'd0);
    endtask

    task automatic t_corner_sweep;
        for (int a = 0; a < 32; a++) begin
            apply("R1 zeros", 32'h0, a[4:0]);
            apply("R3 ones", 32'hFFFFFFFF, a[4:0]);
            apply("R9 bit0", 32'h1, a[4:0]);
            apply("R4 bit31", 32'h80000000, a[4:0]);
        end
    endtask

    task automatic t_fine;
        for (int a = 1; a < 4; a++) apply("R5", 32'hA5C3_0F96, a[4:0]);
    endtask

    task automatic t_coarse;
        for (int a = 4; a <= 12; a += 4) apply("R6", 32'h1234_5678, a[4:0]);
    endtask

    task automatic t_half;
        apply("R7", 32'hCAFE_F00D, 5'd16);
        check("R7 low half", {16'h0, res[15:0]}, 32'h0);
    endtask

    task automatic t_random;
        for (int i = 0; i < 200; i++) apply("R1 rand", $urandom, 5'($urandom));
    endtask

    task automatic t_comb;
        @(posedge clk);
        op = 32'h0000_00F0; amt = 5'd3;
        #1;
        check("R8 first", res, 32'h0000_0780);
        amt = 5'd20;
        #1;
        check("R8 second", res, 32'h0F00_0000);
    endtask

    initial begin
        t_reset_state();
        t_zero_amount();
        t_corner_sweep();
        t_fine();
        t_coarse();
        t_half();
        t_random();
        t_comb();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp<=20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule